// File: doc/BRIEF.md
# Reconfigurable Three-Section Biquad IIR Filter

The block holds three second-order recursive sections (biquads) and a routing stage. A two-bit mode input chains them in one of three ways. All three can form a single sixth-order filter on one stream. They can run as three unrelated second-order filters on three streams at once. Or the first two can form a fourth-order filter while the third filters a separate stream. Multiplexers in front of each section pick its input from an input lane or from the previous section's output. A second multiplexer stage maps section outputs onto the three output lanes.

Samples are 16-bit signed and travel on three lanes, each with its own valid bit. The filter coefficients are 16-bit signed with 14 fraction bits. They sit in a register bank that is written one word at a time. Every section output is rounded and clipped to 16 bits and is registered, so a chained path costs one cycle per section. A synchronous clear input or any change of mode zeroes all delay-line state, so a new configuration always starts from rest.

Top module: `biquad_trio_iir`

## Requirements
- R1: After reset all output valids and output data are zero, and every section has b0 = 16384 (1.0) and all other coefficients 0, so each section passes its input through unchanged.
- R2: A section, on each valid input x, produces y = round((b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) / 2^14), computed at full precision. Here x1 and x2 are its previous two accepted inputs and y1 and y2 its previous two outputs. Rounding adds 2^13 and then shifts arithmetically right by 14.
- R3: Every section result is clipped to the range −32768..32767, and the clipped value is the one stored as y1.
- R4: Mode 0 chains sections 0, 1 and 2. Lane 0 input appears filtered on lane 0 output three cycles later. Output lanes 1 and 2 never assert valid, and input lanes 1 and 2 are ignored.
- R5: Modes 1 and 3 run three independent sections. Input lane i goes through section i to output lane i with one cycle of latency.
- R6: Mode 2 chains sections 0 and 1 from lane 0 to lane 0 with two cycles of latency. Section 2 filters lane 2 to lane 2 with one cycle of latency. Input lane 1 is ignored and output lane 1 never asserts valid.
- R7: A write with cfg_we_i high stores cfg_data_i into the coefficient chosen by cfg_addr_i. Bits [4:3] select the section (0..2) and bits [2:0] the index: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2. The new value applies to every sample accepted in a later cycle.
- R8: Writes with a section field of 3, or an index of 5 to 7, change no coefficient.
- R9: While clr_i is high at a clock edge, all delay lines are zeroed and any sample or in-flight result at that edge is dropped. All output valids are low after that edge.
- R10: A clock edge at which mode_i differs from the mode used at the previous edge behaves as a clear (R9) and adopts the new mode.
- R11: Lanes may carry gaps. A section's state advances only on a valid input, and output data on a lane whose valid is low reads zero.
- Lane i of in_data_i and out_data_o occupies bits [16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Section arrangement: 0 chain of three, 1/3 parallel, 2 chain of two plus one |
| clr_i | input | 1 | Synchronous clear of all delay lines |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | 5 | Coefficient address: section in [4:3], index in [2:0] |
| cfg_data_i | input | 16 | Coefficient value, signed Q2.14 |
| in_valid_i | input | 3 | Per-lane input sample valid |
| in_data_i | input | 48 | Three packed signed input samples |
| out_valid_o | output | 3 | Per-lane output sample valid |
| out_data_o | output | 48 | Three packed signed output samples |

## Verification
The arrangements are swept with four stimulus shapes, each separating a different class of fault. A single impulse exposes wrong tap ordering or a wrong feedback sign. Pseudo-random samples with irregular gaps show whether state advances only on valid samples. A full-scale square wave against near-2.0 coefficients drives both clip limits. A constant step checks steady-state gain in the alternate parallel encoding. Runs in the same mode after a clear, and runs that follow a mode switch, show whether old state leaks into a new configuration. Writes to unused addresses between runs show whether they corrupt live coefficients.

// File: rtl/tbq_pkg.sv
package tbq_pkg;
  localparam int unsigned NSEC  = 3;
  localparam int unsigned NCOEF = 5;
  localparam int unsigned SECW  = 2;
  localparam int unsigned IDXW  = 3;
  localparam int unsigned CAW   = SECW + IDXW;

  typedef enum logic [1:0] {
    MODE_CASC6   = 2'd0,
    MODE_PAR3    = 2'd1,
    MODE_SPLIT42 = 2'd2,
    MODE_PAR3B   = 2'd3
  } mode_e;

  localparam int unsigned K_B0 = 0;
  localparam int unsigned K_B1 = 1;
  localparam int unsigned K_B2 = 2;
  localparam int unsigned K_A1 = 3;
  localparam int unsigned K_A2 = 4;
endpackage

// File: rtl/tbq_coef_bank.sv
module tbq_coef_bank
  import tbq_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 14
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [CAW-1:0]              addr_i,
  input  logic [CW-1:0]               data_i,
  output logic [NSEC*NCOEF*CW-1:0]    coef_o
);
  localparam logic [CW-1:0] UNITY = {{(CW-1){1'b0}}, 1'b1} << FRAC;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    for (genvar k = 0; k < NCOEF; k++) begin : g_coef
      logic          hit;
      logic [CW-1:0] q;
      assign hit = we_i && (addr_i[CAW-1:IDXW] == SECW'(s)) && (addr_i[IDXW-1:0] == IDXW'(k));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= (k == K_B0) ? UNITY : '0;
        else if (hit) q <= data_i;
      end
      assign coef_o[(s*NCOEF+k)*CW +: CW] = q;
    end
  end
endmodule

// File: rtl/tbq_section.sv
module tbq_section
  import tbq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   in_valid_i,
  input  logic signed [DW-1:0]   in_data_i,
  input  logic [NCOEF*CW-1:0]    coef_i,
  output logic                   out_valid_o,
  output logic signed [DW-1:0]   out_data_o
);
  localparam int unsigned PW = DW + CW;
  localparam int unsigned AW = PW + 3;
  localparam logic signed [AW-1:0] MAXV = $signed({{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [AW-1:0] MINV = $signed({{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}});
  localparam logic signed [AW-1:0] RND  = $signed({{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}});

  logic signed [CW-1:0] cb0, cb1, cb2, ca1, ca2;
  logic signed [DW-1:0] x1_q, x2_q, y1_q, y2_q;
  logic signed [PW-1:0] p_b0, p_b1, p_b2, p_a1, p_a2;
  logic signed [AW-1:0] acc, shifted;
  logic signed [DW-1:0] y_sat;

  assign cb0 = coef_i[K_B0*CW +: CW];
  assign cb1 = coef_i[K_B1*CW +: CW];
  assign cb2 = coef_i[K_B2*CW +: CW];
  assign ca1 = coef_i[K_A1*CW +: CW];
  assign ca2 = coef_i[K_A2*CW +: CW];

  assign p_b0 = PW'(cb0) * PW'(in_data_i);
  assign p_b1 = PW'(cb1) * PW'(x1_q);
  assign p_b2 = PW'(cb2) * PW'(x2_q);
  assign p_a1 = PW'(ca1) * PW'(y1_q);
  assign p_a2 = PW'(ca2) * PW'(y2_q);

  assign acc     = AW'(p_b0) + AW'(p_b1) + AW'(p_b2) - AW'(p_a1) - AW'(p_a2);
  assign shifted = (acc + RND) >>> FRAC;

  always_comb begin
    if (shifted > MAXV)      y_sat = MAXV[DW-1:0];
    else if (shifted < MINV) y_sat = MINV[DW-1:0];
    else                     y_sat = shifted[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0; x2_q <= '0; y1_q <= '0; y2_q <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (clr_i) begin
      x1_q <= '0; x2_q <= '0; y1_q <= '0; y2_q <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        x2_q <= x1_q;
        x1_q <= in_data_i;
        y2_q <= y1_q;
        y1_q <= y_sat;
        out_data_o <= y_sat;
      end
    end
  end
endmodule

// File: rtl/biquad_trio_iir.sv
module biquad_trio_iir
  import tbq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               clr_i,
  input  logic               cfg_we_i,
  input  logic [CAW-1:0]     cfg_addr_i,
  input  logic [CW-1:0]      cfg_data_i,
  input  logic [NSEC-1:0]    in_valid_i,
  input  logic [NSEC*DW-1:0] in_data_i,
  output logic [NSEC-1:0]    out_valid_o,
  output logic [NSEC*DW-1:0] out_data_o
);
  mode_e mode_q;
  logic  flush;
  logic [NSEC*NCOEF*CW-1:0] coef_all;

  logic [NSEC-1:0]      vin, vout;
  logic signed [DW-1:0] xin  [NSEC];
  logic signed [DW-1:0] yout [NSEC];
  logic [NSEC-1:0]      ovld;
  logic signed [DW-1:0] odat [NSEC];

  assign flush = clr_i || (mode_e'(mode_i) != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CASC6;
    else         mode_q <= mode_e'(mode_i);
  end

  tbq_coef_bank #(.CW(CW), .FRAC(FRAC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .coef_o (coef_all)
  );

  // input selection: a section reads its own lane or the previous section
  always_comb begin
    for (int s = 0; s < NSEC; s++) begin
      vin[s] = in_valid_i[s];
      xin[s] = in_data_i[s*DW +: DW];
    end
    case (mode_q)
      MODE_CASC6: begin
        vin[1] = vout[0]; xin[1] = yout[0];
        vin[2] = vout[1]; xin[2] = yout[1];
      end
      MODE_SPLIT42: begin
        vin[1] = vout[0]; xin[1] = yout[0];
      end
      default: ;
    endcase
  end

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    tbq_section #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_sec (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (flush),
      .in_valid_i  (vin[s]),
      .in_data_i   (xin[s]),
      .coef_i      (coef_all[s*NCOEF*CW +: NCOEF*CW]),
      .out_valid_o (vout[s]),
      .out_data_o  (yout[s])
    );
  end

  // output selection: lanes carry only the end of each active chain
  always_comb begin
    ovld = '0;
    for (int l = 0; l < NSEC; l++) odat[l] = yout[l];
    case (mode_q)
      MODE_CASC6: begin
        ovld[0] = vout[2]; odat[0] = yout[2];
      end
      MODE_SPLIT42: begin
        ovld[0] = vout[1]; odat[0] = yout[1];
        ovld[2] = vout[2];
      end
      default: ovld = vout;
    endcase
    for (int l = 0; l < NSEC; l++)
      out_data_o[l*DW +: DW] = ovld[l] ? odat[l] : '0;
  end

  assign out_valid_o = ovld;
endmodule

// File: rtl/biquad_trio_iir_chk.sv
module biquad_trio_iir_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       clr_i,
  input logic [2:0] in_valid_i,
  input logic [2:0] out_valid_o
);
  logic       seen_q;
  logic [1:0] prev_mode_q;
  logic [1:0] run_q;
  logic       clean;

  assign clean = seen_q && !clr_i && (mode_i == prev_mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; prev_mode_q <= 2'd0; run_q <= 2'd0;
    end else begin
      seen_q      <= 1'b1;
      prev_mode_q <= mode_i;
      run_q       <= !clean ? 2'd0 : (run_q == 2'd3) ? 2'd3 : run_q + 2'd1;
    end
  end

  p_clr_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> out_valid_o == 3'b000);

  p_mode_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mode_i != prev_mode_q) |=> out_valid_o == 3'b000);

  // R5 R6: lane 1 output only in the parallel arrangements
  p_lane1_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && out_valid_o[1]) |-> (prev_mode_q == 2'd1 || prev_mode_q == 2'd3));

  p_lane2_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && out_valid_o[2]) |-> prev_mode_q != 2'd0);

  p_lat_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean && (mode_i == 2'd1 || mode_i == 2'd3)) |=> out_valid_o[1] == $past(in_valid_i[1]));

  p_lat_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == 2'd3 && prev_mode_q == 2'd0) |-> out_valid_o[0] == $past(in_valid_i[0], 3));
endmodule

bind biquad_trio_iir biquad_trio_iir_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .clr_i       (clr_i),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o)
);

// File: tb/biquad_trio_iir_tb_top.sv
module biquad_trio_iir_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        clr_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_addr_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic [2:0]  in_valid_i = '0;
  logic [47:0] in_data_i = '0;
  logic [2:0]  out_valid_o;
  logic [47:0] out_data_o;

  always #10 clk = ~clk;

  biquad_trio_iir dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .clr_i(clr_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int coef_m [3][5];
  int sx1 [3], sx2 [3], sy1 [3], sy2 [3];
  int stim [3][64];
  int stim_cyc [3][64];
  int nin [3];
  int got [3][128];
  int got_cyc [3][128];
  int nout [3];
  int lcg = 32'h1234_5678;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_step(int s, int x);
    longint acc, r;
    int y;
    acc = longint'(coef_m[s][0]) * x + longint'(coef_m[s][1]) * sx1[s]
        + longint'(coef_m[s][2]) * sx2[s] - longint'(coef_m[s][3]) * sy1[s]
        - longint'(coef_m[s][4]) * sy2[s];
    r = (acc + 8192) >>> 14;
    y = (r > 32767) ? 32767 : (r < -32768) ? -32768 : int'(r);
    sx2[s] = sx1[s]; sx1[s] = x; sy2[s] = sy1[s]; sy1[s] = y;
    return y;
  endfunction

  task automatic wr_coef(input int s, input int k, input int v);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 5'((s << 3) | k); cfg_data_i = 16'(v);
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (s < 3 && k < 5) coef_m[s][k] = v;  // R7/R8 bench view
  endtask

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return int'($signed(16'(lcg >>> 12)));
  endfunction

  // kind: 0 impulse, 1 random, 2 full-scale square, 3 step
  task automatic run_test(input int mode, input bit use_clr, input int ns, input int kind,
                          input bit gaps, input string tag);
    int first, len;
    @(negedge clk);
    mode_i = 2'(mode); clr_i = use_clr; in_valid_i = '0;
    @(negedge clk);
    clr_i = 1'b0;
    for (int s = 0; s < 3; s++) begin
      sx1[s] = 0; sx2[s] = 0; sy1[s] = 0; sy2[s] = 0;
      nin[s] = 0; nout[s] = 0;
    end
    for (int c = 0; c < ns + 6; c++) begin
      for (int l = 0; l < 3; l++) begin
        if (out_valid_o[l]) begin
          got[l][nout[l]] = int'($signed(out_data_o[l*16 +: 16]));
          got_cyc[l][nout[l]] = c;
          nout[l]++;
        end else begin
          chk({tag, " R11 idle lane data"}, int'(out_data_o[l*16 +: 16]), 0);
        end
      end
      for (int l = 0; l < 3; l++) begin
        bit v;
        int x;
        v = (c < ns) && (!gaps || ((c * 7 + l * 3) % 5 != 0));
        case (kind)
          0: x = (nin[l] == 0) ? 8192 + l * 1000 : 0;
          1: x = next_rand();
          2: x = ((nin[l] / 3) % 2 == 0) ? 32767 : -32768;
          default: x = 20000 - l * 15000;
        endcase
        in_valid_i[l] = v;
        in_data_i[l*16 +: 16] = 16'(x);
        if (v) begin
          stim[l][nin[l]] = x; stim_cyc[l][nin[l]] = c; nin[l]++;
        end
      end
      @(negedge clk);
    end
    in_valid_i = '0;
    for (int l = 0; l < 3; l++) begin
      first = l; len = 1;
      if (mode == 0) begin first = 0; len = (l == 0) ? 3 : 0; end
      if (mode == 2) begin
        if (l == 0) len = 2;
        if (l == 1) len = 0;
      end
      chk({tag, " output count"}, nout[l], (len == 0) ? 0 : nin[l]);
      if (len != 0) begin
        for (int k = 0; k < nin[l] && k < nout[l]; k++) begin
          int y;
          y = stim[l][k];
          for (int s = first; s < first + len; s++) y = model_step(s, y);
          chk({tag, " R2 R3 sample value"}, got[l][k], y);
          chk({tag, " latency"}, got_cyc[l][k] - stim_cyc[l][k], len);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 5; k++) coef_m[s][k] = (k == 0) ? 16384 : 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid_o), 0);
    chk("R1 data after reset lane0", int'(out_data_o[15:0]), 0);

    // R1: default coefficients pass samples through
    run_test(1, 1'b1, 20, 1, 1'b0, "R1 R5 passthrough");

    // R7: load filters
    wr_coef(0, 0, 4096);  wr_coef(0, 1, 8192);   wr_coef(0, 2, 4096);
    wr_coef(0, 3, -8192); wr_coef(0, 4, 2048);
    wr_coef(1, 0, 16384); wr_coef(1, 1, -16384); wr_coef(1, 2, 3000);
    wr_coef(1, 3, 4096);  wr_coef(1, 4, -2048);
    wr_coef(2, 0, 12000); wr_coef(2, 1, 3000);   wr_coef(2, 2, -5000);
    wr_coef(2, 3, -12000); wr_coef(2, 4, 6000);

    run_test(0, 1'b1, 30, 0, 1'b0, "R4 R7 impulse chain6");
    run_test(0, 1'b1, 30, 1, 1'b1, "R4 R9 R11 random chain6 after clear");

    // R8: writes to unused addresses
    wr_coef(3, 0, 31000); wr_coef(3, 4, -31000);
    wr_coef(0, 5, 31000); wr_coef(1, 6, 31000); wr_coef(2, 7, -31000);

    run_test(1, 1'b0, 30, 1, 1'b1, "R5 R8 R10 parallel after mode switch");
    run_test(2, 1'b0, 30, 1, 1'b1, "R6 R10 split");
    run_test(3, 1'b0, 25, 3, 1'b0, "R5 R10 alt parallel step");

    // R3: gain near 6 drives both clip limits
    wr_coef(0, 0, 32767); wr_coef(0, 1, 32767); wr_coef(0, 2, 32767);
    wr_coef(0, 3, 0);     wr_coef(0, 4, 0);
    run_test(1, 1'b1, 24, 2, 1'b0, "R3 saturation");
    run_test(0, 1'b1, 24, 2, 1'b0, "R3 R4 saturation chain6");

    // R9: clear with samples in flight
    @(negedge clk);
    mode_i = 2'd1; in_valid_i = 3'b111; in_data_i = {16'd300, 16'd200, 16'd100};
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    chk("R9 valids after clear", int'(out_valid_o), 0);
    clr_i = 1'b0; in_valid_i = '0;
    @(negedge clk);
    chk("R9 valids idle after clear", int'(out_valid_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule